// File: doc/BRIEF.md
# Memory-Mapped Parallel I/O Port

This block joins one 8-bit input device and one 8-bit output device to a processor bus. The bus uses a full ready handshake. The processor raises a master request with an address, a read/write line and write data. The port answers with an acknowledge. It holds that acknowledge until the request drops, and only then lowers it again. The address bits above bit 1 are compared with a base-address parameter to select the port. The two lowest bits then pick one of three registers: the latched input character, the outgoing character, or a two-flag status word.

On the device side, each rising edge of the input device's strobe captures its data byte and raises the input-ready flag. The strobe first passes through a two-flop synchronizer. A processor write of the outgoing character drives that byte to the output device and raises the output strobe. The output strobe stays high until the device signals idle. Idle also raises the output-ready flag. Instead of three-state drivers, the port presents read data with a separate read-enable. The enable is high only while a decoded read is being acknowledged.

The bus request, address and idle lines are sampled directly in the port's clock domain. Only the input device's strobe is synchronized.

Top module: `pario_port`

## Requirements
- R1: After reset, the acknowledge, read-enable and output strobe are low, and both status flags read 0.
- R2: An access is decoded only when address bits [31:2] equal BASE_WORD (default 0x0400_0000, so the port occupies byte addresses 0x1000_0000 to 0x1000_0003). Any other address gets no acknowledge and changes no register.
- R3: A rising edge on `in_strobe` captures `in_data` and sets the input-ready flag (status bit 0). Both are visible at the bus no more than three clocks after the edge.
- R4: A read at offset 0 returns the captured input byte and clears the input-ready flag. If a new input edge is captured in the same cycle, the flag stays set.
- R5: A read at offset 2 returns the status word: bit 0 is the input-ready flag, bit 1 is the output-ready flag, and bits 7:2 are 0.
- R6: A write at offset 1 drives the written byte on `out_data`, raises `out_strobe` and clears the output-ready flag, all on the clock edge that accepts the write.
- R7: While `out_idle` is high and no write to offset 1 is accepted in that cycle, the output-ready flag is set and `out_strobe` is lowered on the next edge.
- R8: The acknowledge rises on the first edge that sees a request decoded as a hit. It stays high while the request stays high, and it falls on the first edge after the request drops. No new access is accepted while the acknowledge is high.
- R9: `bus_rden` is high only while a read is acknowledged. It stays low for every write.
- R10: Offset 3, writes to offsets 0 and 2, and reads of offset 1 get no acknowledge and leave every register unchanged.
- R11: An input strobe held high captures only once. A data change while the strobe stays high is not loaded and does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_wdata | input | DATA_W | Write data from the processor |
| bus_mreq | input | 1 | Master request strobe |
| bus_sack | output | 1 | Slave acknowledge |
| bus_rdata | output | DATA_W | Read data |
| bus_rden | output | 1 | Read-data drive enable |
| in_data | input | DATA_W | Input device data |
| in_strobe | input | 1 | Input device valid strobe (asynchronous) |
| out_data | output | DATA_W | Outgoing character |
| out_strobe | output | 1 | Valid strobe to the output device |
| out_idle | input | 1 | Output device ready for a character |

## Verification
If the port is stuck in its acknowledge state, the acknowledge is still high on the cycle after the request drops. A stale flag shows up on the very next status read. Capture logic that fires on a level instead of an edge sets the input flag again after it has been read, while the strobe is still held high. A bad decode shows as an acknowledge on a foreign or unsupported address. It can also show as a changed byte on `out_data`, or as a changed input byte on the next read.

// File: rtl/pario_pkg.sv
package pario_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        SEL_IN   = 2'd0,
        SEL_OUT  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              busy;
        logic              rden;
        logic [DATA_W-1:0] rdata;
        logic [DATA_W-1:0] in_byte;
        logic              in_rdy;
        logic [DATA_W-1:0] out_byte;
        logic              out_vld;
        logic              out_rdy;
    } port_state_t;
endpackage

// File: rtl/pario_in_sync.sv
module pario_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] pipe_q;
    logic [STAGES:0] pipe_d;

    genvar g;
    generate
        for (g = 0; g <= STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign pipe_d[g] = async_i;
            end else begin : g_next
                assign pipe_d[g] = pipe_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/pario_decode.sv
module pario_decode #(
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-3:0] BASE_WORD = '0
) (
    input  logic              mreq_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rnw_i,
    output logic              rd_in_o,
    output logic              wr_out_o,
    output logic              rd_stat_o
);
    import pario_pkg::*;

    logic     match;
    reg_sel_e sel;

    always_comb begin
        match     = mreq_i && (addr_i[ADDR_W-1:2] == BASE_WORD);
        sel       = reg_sel_e'(addr_i[1:0]);
        rd_in_o   = match &&  rnw_i && (sel == SEL_IN);
        wr_out_o  = match && !rnw_i && (sel == SEL_OUT);
        rd_stat_o = match &&  rnw_i && (sel == SEL_STAT);
    end
endmodule

// File: rtl/pario_port.sv
module pario_port #(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 8,
    parameter int                SYNC_STG  = 2,
    parameter logic [ADDR_W-3:0] BASE_WORD = 30'h0400_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rnw,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_mreq,
    output logic              bus_sack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rden,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_strobe,
    output logic [DATA_W-1:0] out_data,
    output logic              out_strobe,
    input  logic              out_idle
);
    import pario_pkg::*;

    localparam int PAD_W = DATA_W - 2;

    port_state_t st_q, st_d;
    logic        in_rise;
    logic        hit_rd_in, hit_wr_out, hit_rd_st;
    logic        accept;
    logic [DATA_W-1:0] stat_word;

    pario_in_sync #(.STAGES(SYNC_STG)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (in_strobe),
        .rise_o  (in_rise)
    );

    pario_decode #(.ADDR_W(ADDR_W), .BASE_WORD(BASE_WORD)) i_dec (
        .mreq_i    (bus_mreq),
        .addr_i    (bus_addr),
        .rnw_i     (bus_rnw),
        .rd_in_o   (hit_rd_in),
        .wr_out_o  (hit_wr_out),
        .rd_stat_o (hit_rd_st)
    );

    always_comb begin
        st_d      = st_q;
        stat_word = {{PAD_W{1'b0}}, st_q.out_rdy, st_q.in_rdy};
        accept    = !st_q.busy && (hit_rd_in || hit_wr_out || hit_rd_st);

        // handshake completion
        if (st_q.busy && !bus_mreq) begin
            st_d.busy = 1'b0;
            st_d.rden = 1'b0;
        end

        if (accept) begin
            st_d.busy  = 1'b1;
            st_d.rden  = hit_rd_in || hit_rd_st;
            st_d.rdata = hit_rd_in ? st_q.in_byte : stat_word;
        end

        // input side: a fresh capture overrides the read clear
        if (accept && hit_rd_in) st_d.in_rdy = 1'b0;
        if (in_rise) begin
            st_d.in_byte = in_data;
            st_d.in_rdy  = 1'b1;
        end

        // output side: an accepted write overrides idle
        if (out_idle) begin
            st_d.out_rdy = 1'b1;
            st_d.out_vld = 1'b0;
        end
        if (accept && hit_wr_out) begin
            st_d.out_byte = bus_wdata;
            st_d.out_vld  = 1'b1;
            st_d.out_rdy  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_sack   = st_q.busy;
    assign bus_rden   = st_q.rden;
    assign bus_rdata  = st_q.rdata;
    assign out_data   = st_q.out_byte;
    assign out_strobe = st_q.out_vld;
endmodule

// File: rtl/pario_port_chk.sv
module pario_port_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_mreq,
    input logic bus_sack,
    input logic bus_rden,
    input logic out_strobe,
    input logic out_idle
);
    AST_SACK_NEEDS_MREQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_sack) |-> $past(bus_mreq)); // R8
    AST_SACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sack && bus_mreq) |=> bus_sack); // R8
    AST_SACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sack && !bus_mreq) |=> !bus_sack); // R8
    AST_RDEN_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rden |-> bus_sack); // R9
    AST_STROBE_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_strobe) |-> $past(out_idle)); // R7
endmodule

bind pario_port pario_port_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_mreq   (bus_mreq),
    .bus_sack   (bus_sack),
    .bus_rden   (bus_rden),
    .out_strobe (out_strobe),
    .out_idle   (out_idle)
);

// File: tb/test_pario_port.sv
module test_pario_port;
    localparam logic [31:0] BASE = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rnw = 1'b1;
    logic [7:0]  bus_wdata = '0;
    logic        bus_mreq = 1'b0;
    logic        bus_sack, bus_rden, out_strobe;
    logic [7:0]  bus_rdata, out_data;
    logic [7:0]  in_data = '0;
    logic        in_strobe = 1'b0;
    logic        out_idle = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pario_port i_pario_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rnw(bus_rnw),
        .bus_wdata(bus_wdata), .bus_mreq(bus_mreq), .bus_sack(bus_sack),
        .bus_rdata(bus_rdata), .bus_rden(bus_rden), .in_data(in_data),
        .in_strobe(in_strobe), .out_data(out_data), .out_strobe(out_strobe),
        .out_idle(out_idle)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one bus access; ok=1 when acknowledged, lat = cycles to acknowledge
    task automatic xfer(input logic [31:0] a, input logic rnw, input logic [7:0] wd,
                        input int hold, output logic [7:0] rd, output logic ok,
                        output logic rden_seen, output int lat);
        @(negedge clk);
        bus_addr = a; bus_rnw = rnw; bus_wdata = wd; bus_mreq = 1'b1;
        ok = 1'b0; lat = -1;
        for (int i = 0; i < 4 && !ok; i++) begin
            @(negedge clk);
            if (bus_sack) begin ok = 1'b1; lat = i; end
        end
        rd = bus_rdata; rden_seen = bus_rden;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (ok) check("R8 held", bus_sack, 1);
        end
        bus_mreq = 1'b0;
        @(negedge clk);
        check("R8 release", bus_sack, 0);
        check("R9 rden off", bus_rden, 0);
    endtask

    task automatic rd_reg(input logic [1:0] off, input string req, input logic [7:0] exp);
        logic [7:0] rd; logic ok, rs; int lat;
        xfer(BASE + off, 1'b1, 8'h00, 0, rd, ok, rs, lat);
        check({req, " ack"}, ok, 1);
        check({req, " data"}, rd, exp);
        check("R9 read enable", rs, 1);
        check("R8 latency", lat, 0);
    endtask

    task automatic pulse_in(input logic [7:0] v);
        @(negedge clk); in_data = v; in_strobe = 1'b1;
        repeat (3) @(negedge clk);
        in_strobe = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 sack", bus_sack, 0);
        check("R1 rden", bus_rden, 0);
        check("R1 out_strobe", out_strobe, 0);
        rd_reg(2'd2, "R1 status", 8'h00);
    endtask

    task automatic t_input;
        pulse_in(8'hA5);
        rd_reg(2'd2, "R3 flag", 8'h01);
        rd_reg(2'd0, "R4 data", 8'hA5);
        rd_reg(2'd2, "R4 cleared", 8'h00);
    endtask

    task automatic t_edge_only;
        @(negedge clk); in_data = 8'h3C; in_strobe = 1'b1;
        repeat (3) @(negedge clk);   // captured within three clocks
        rd_reg(2'd2, "R3 latency", 8'h01);
        rd_reg(2'd0, "R3 data", 8'h3C);
        in_data = 8'h99;
        repeat (4) @(negedge clk);
        rd_reg(2'd2, "R11 no reload flag", 8'h00);
        rd_reg(2'd0, "R11 no reload data", 8'h3C);
        in_strobe = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_output;
        logic [7:0] rd; logic ok, rs; int lat;
        out_idle = 1'b0;
        xfer(BASE + 1, 1'b0, 8'h5A, 0, rd, ok, rs, lat);
        check("R6 ack", ok, 1);
        check("R9 write no rden", rs, 0);
        check("R6 out_data", out_data, 8'h5A);
        check("R6 out_strobe", out_strobe, 1);
        rd_reg(2'd2, "R6 status", 8'h00);
        repeat (3) @(negedge clk);
        check("R6 strobe held", out_strobe, 1);
        out_idle = 1'b1;
        @(negedge clk);
        check("R7 strobe drop", out_strobe, 0);
        out_idle = 1'b0;
        rd_reg(2'd2, "R7 status", 8'h02);
        check("R5 data kept", out_data, 8'h5A);
    endtask

    task automatic t_decode;
        logic [7:0] rd; logic ok, rs; int lat;
        xfer(BASE + 32'h4, 1'b1, 8'h00, 0, rd, ok, rs, lat);
        check("R2 foreign read", ok, 0);
        xfer(BASE ^ 32'h8000_0001, 1'b0, 8'hEE, 0, rd, ok, rs, lat);
        check("R2 foreign write", ok, 0);
        check("R2 out_data kept", out_data, 8'h5A);
        check("R2 strobe kept", out_strobe, 0);
        xfer(BASE + 3, 1'b1, 8'h00, 0, rd, ok, rs, lat);
        check("R10 offset3", ok, 0);
        xfer(BASE + 0, 1'b0, 8'h77, 0, rd, ok, rs, lat);
        check("R10 write in", ok, 0);
        xfer(BASE + 2, 1'b0, 8'h00, 0, rd, ok, rs, lat);
        check("R10 write status", ok, 0);
        xfer(BASE + 1, 1'b1, 8'h00, 0, rd, ok, rs, lat);
        check("R10 read out", ok, 0);
        rd_reg(2'd0, "R10 in kept", 8'h3C);
        rd_reg(2'd2, "R10 status kept", 8'h02);
    endtask

    task automatic t_long_hold;
        logic [7:0] rd; logic ok, rs; int lat;
        pulse_in(8'h42);
        xfer(BASE + 2, 1'b1, 8'h00, 5, rd, ok, rs, lat);
        check("R8 long ack", ok, 1);
        check("R5 both flags", rd, 8'h03);
        check("R8 single access", rs, 1);
        rd_reg(2'd2, "R8 no re-access", 8'h03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_input();
        t_edge_only();
        t_output();
        t_decode();
        t_long_hold();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule